// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block picks a small number of interrupt sources out of a wide bank of GPIO pad inputs and hands them to a downstream interrupt controller that only accepts active-high requests. Eight output channels each own an 8-bit pad index, a sense-inversion bit, a level/edge mode bit and a 4-bit glitch-filter code. Every pad is brought into the clock domain through a two-flop synchronizer. The selected pad is then optionally inverted, filtered and, in edge mode, turned into a one-clock pulse.

Software decides which pad goes to which channel and programs the choice through a word-addressed register port. The port has one mode/inversion word, two pad-index words and one filter word. Inversion is what lets a falling-edge or low-level source reach a controller that only understands rising edges and high levels. Sensing both edges on a single channel is not possible.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset every configuration word reads zero, which means level mode, no inversion, pad 0 and no filtering, and every channel output is low.
- R2: Word address 0 holds the mode bit of channel n at bit n (1 = edge) and its inversion bit at bit 16+n. Word address 1 holds the pad index of channels 0 to 3, and word address 2 holds those of channels 4 to 7, each at bit (n mod 4)*8. Word address 3 holds the filter code of channel n at bits 4n+3..4n. Unused bits read as zero, and a write replaces the whole word.
- R3: A pad change reaches a level-mode channel with filter code 0 on the third rising clock edge after it. Two edges are spent in the synchronizer and one in the filter stage.
- R4: A channel responds only to the pad named by its index, and every other pad has no effect on it.
- R5: With the inversion bit set, the channel senses the complement of its pad, so a low pad or a falling pad becomes an active request.
- R6: In level mode the output is high exactly while the filtered, possibly inverted signal is high.
- R7: In edge mode the output is high for exactly one clock after the filtered signal goes from 0 to 1, and no pulse follows a 1 to 0 change.
- R8: With filter code k greater than 0, the filtered value changes only after the sensed input has held the new value for 2k consecutive clocks, and a shorter glitch is dropped. Code 0 applies no filtering.
- R9: Changing a channel's pad index or inversion bit never produces an edge pulse on that channel.
- R10: Channels are independent: activity on one channel's pad leaves the other channels' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pads | input | NUM_PADS | Asynchronous GPIO pad levels |
| reg_valid | input | 1 | Register access strobe |
| reg_we | input | 1 | Write enable for the access |
| reg_addr | input | 2 | Word address of the configuration register |
| reg_wdata | input | 32 | Write data, a full word |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | NUM_CH | Active-high channel requests |

## Verification
A register write that retargets a channel can land in the same cycle that the edge detector would see the newly selected pad as a fresh rising input. The bench provokes this by holding a pad high and then writing its index into a channel that sits in edge mode and currently watches a low pad. It does the same by toggling the inversion bit while the sensed level flips. It then watches the channel output over every following cycle and judges the case correct only if no pulse appears. A genuine edge on the same channel is then shown to still produce exactly one pulse.

// File: rtl/gim_pkg.sv
package gim_pkg;
   localparam int GIM_DATA_W   = 32;
   localparam int GIM_SEL_SLOT = 8;   // bits per pad-index slot
   localparam int GIM_FLT_SLOT = 4;   // bits per filter-code slot
   localparam int GIM_INV_BASE = 16;  // first inversion bit in the mode word
   localparam int GIM_SEL_PER_WORD = GIM_DATA_W / GIM_SEL_SLOT;

   typedef enum logic [1:0] {
      GIM_MODE_WORD = 2'd0,
      GIM_SEL_LO    = 2'd1,
      GIM_SEL_HI    = 2'd2,
      GIM_FLT_WORD  = 2'd3
   } gim_addr_e;
endpackage

// File: rtl/gim_sync.sv
module gim_sync #(
   parameter int W = 256
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q;
   logic [W-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= d_i;
         sync_q <= meta_q;
      end
   end

   assign q_o = sync_q;

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   assert_sync_two_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gim_regs.sv
module gim_regs
   import gim_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int SEL_W  = 8,
   parameter int FILT_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_i,
   input  logic [1:0]                    addr_i,
   input  logic [GIM_DATA_W-1:0]         wdata_i,
   output logic [GIM_DATA_W-1:0]         rdata_o,
   output logic [NUM_CH-1:0][SEL_W-1:0]  sel_o,
   output logic [NUM_CH-1:0]             edge_o,
   output logic [NUM_CH-1:0]             inv_o,
   output logic [NUM_CH-1:0][FILT_W-1:0] code_o
);
   logic [GIM_DATA_W-1:0] w_mode, w_lo, w_hi, w_flt;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam gim_addr_e SEL_WORD = (c < GIM_SEL_PER_WORD) ? GIM_SEL_LO : GIM_SEL_HI;
      localparam int SEL_LSB = (c % GIM_SEL_PER_WORD) * GIM_SEL_SLOT;
      localparam int FLT_LSB = c * GIM_FLT_SLOT;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_o[c]  <= '0;
            edge_o[c] <= 1'b0;
            inv_o[c]  <= 1'b0;
            code_o[c] <= '0;
         end else if (wr_i) begin
            if (addr_i == GIM_MODE_WORD) begin
               edge_o[c] <= wdata_i[c];
               inv_o[c]  <= wdata_i[GIM_INV_BASE + c];
            end
            if (addr_i == SEL_WORD)     sel_o[c]  <= wdata_i[SEL_LSB +: SEL_W];
            if (addr_i == GIM_FLT_WORD) code_o[c] <= wdata_i[FLT_LSB +: FILT_W];
         end
      end

      assert_sel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && addr_i == SEL_WORD) |=> (sel_o[c] == $past(wdata_i[SEL_LSB +: SEL_W])));
   end

   always_comb begin
      w_mode = '0;
      w_lo   = '0;
      w_hi   = '0;
      w_flt  = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         w_mode[c]                = edge_o[c];
         w_mode[GIM_INV_BASE + c] = inv_o[c];
         w_flt[c*GIM_FLT_SLOT +: FILT_W] = code_o[c];
         if (c < GIM_SEL_PER_WORD) w_lo[(c % GIM_SEL_PER_WORD)*GIM_SEL_SLOT +: SEL_W] = sel_o[c];
         else                      w_hi[(c % GIM_SEL_PER_WORD)*GIM_SEL_SLOT +: SEL_W] = sel_o[c];
      end
   end

   always_comb begin
      unique case (gim_addr_e'(addr_i))
         GIM_MODE_WORD: rdata_o = w_mode;
         GIM_SEL_LO:    rdata_o = w_lo;
         GIM_SEL_HI:    rdata_o = w_hi;
         default:       rdata_o = w_flt;
      endcase
   end
endmodule

// File: rtl/gim_channel.sv
module gim_channel #(
   parameter int NUM_PADS  = 256,
   parameter int SEL_W     = 8,
   parameter int FILT_W    = 4,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PADS-1:0] pads_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic                inv_i,
   input  logic                edge_i,
   input  logic [FILT_W-1:0]   code_i,
   output logic                irq_o
);
   localparam int CNT_W = FILT_W + 1;
   localparam logic [SEL_W:0] PAD_LIM = (SEL_W+1)'(NUM_PADS);

   logic             picked, raw, reseed;
   logic             filt_q, prev_q, inv_q;
   logic [SEL_W-1:0] sel_q;

   assign picked = ({1'b0, sel_i} < PAD_LIM) ? pads_i[sel_i] : 1'b0;
   assign raw    = picked ^ inv_i;
   assign reseed = (sel_i != sel_q) || (inv_i != inv_q);

   if (FILTER_EN) begin : g_filter
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] last;
      assign last = {code_i, 1'b0} - CNT_W'(1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
         end else if (reseed || code_i == '0) begin
            filt_q <= raw;
            cnt_q  <= '0;
         end else if (raw == filt_q) begin
            cnt_q  <= '0;
         end else if (cnt_q == last) begin
            filt_q <= raw;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
         end
      end

      assert_filter_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (code_i != '0 && !reseed && raw == filt_q) |=> $stable(filt_q));
   end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) filt_q <= 1'b0;
         else        filt_q <= raw;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         sel_q  <= '0;
         inv_q  <= 1'b0;
      end else begin
         prev_q <= reseed ? raw : filt_q;
         sel_q  <= sel_i;
         inv_q  <= inv_i;
      end
   end

   assign irq_o = edge_i ? (filt_q & ~prev_q) : filt_q;

   assert_pulse_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && irq_o) |=> (!irq_o || !edge_i));
   assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && irq_o) |-> $rose(filt_q));
   assert_retarget_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reseed && edge_i) |=> (!irq_o || !edge_i));
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
   import gim_pkg::*;
#(
   parameter int NUM_PADS  = 256,
   parameter int NUM_CH    = 8,
   parameter int SEL_W     = 8,
   parameter int FILT_W    = 4,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PADS-1:0]   pads,
   input  logic                  reg_valid,
   input  logic                  reg_we,
   input  logic [1:0]            reg_addr,
   input  logic [GIM_DATA_W-1:0] reg_wdata,
   output logic [GIM_DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0]     irq_out
);
   if (NUM_CH < 1 || NUM_CH > 2*GIM_SEL_PER_WORD || NUM_CH > GIM_INV_BASE) begin : g_bad_ch
      $error("gpio_irq_mux: NUM_CH out of range");
   end
   if (SEL_W > GIM_SEL_SLOT || NUM_PADS > (1 << SEL_W)) begin : g_bad_sel
      $error("gpio_irq_mux: SEL_W or NUM_PADS out of range");
   end
   if (FILT_W > GIM_FLT_SLOT) begin : g_bad_flt
      $error("gpio_irq_mux: FILT_W out of range");
   end

   logic [NUM_PADS-1:0]             pads_s;
   logic [NUM_CH-1:0][SEL_W-1:0]    sel;
   logic [NUM_CH-1:0]               edge_m, inv;
   logic [NUM_CH-1:0][FILT_W-1:0]   code;

   gim_sync #(.W(NUM_PADS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pads), .q_o(pads_s)
   );

   gim_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .FILT_W(FILT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_valid && reg_we), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .sel_o(sel), .edge_o(edge_m),
      .inv_o(inv), .code_o(code)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      gim_channel #(.NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .FILT_W(FILT_W),
                    .FILTER_EN(FILTER_EN)) u_ch (
         .clk(clk), .rst_n(rst_n), .pads_i(pads_s), .sel_i(sel[c]), .inv_i(inv[c]),
         .edge_i(edge_m[c]), .code_i(code[c]), .irq_o(irq_out[c])
      );
   end

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/gpio_irq_mux_tb_top.sv
module gpio_irq_mux_tb_top;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] pads = '0;
   logic         reg_valid = 1'b0, reg_we = 1'b0;
   logic [1:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [7:0]   irq_out;

   int checks = 0, errors = 0;
   logic [31:0] sh_mode = '0, sh_lo = '0, sh_hi = '0, sh_flt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_mux dut_i (
      .clk(clk), .rst_n(rst_n), .pads(pads), .reg_valid(reg_valid), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   // {ch[2:0], pad[7:0], inv, drive, expected}
   localparam logic [13:0] VEC [0:5] = '{
      {3'd0, 8'd5,   1'b0, 1'b1, 1'b1},
      {3'd3, 8'd200, 1'b0, 1'b1, 1'b1},
      {3'd7, 8'd255, 1'b0, 1'b0, 1'b0},
      {3'd4, 8'd17,  1'b1, 1'b0, 1'b1},
      {3'd6, 8'd128, 1'b1, 1'b1, 1'b0},
      {3'd2, 8'd64,  1'b0, 1'b1, 1'b1}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic watch(int n, int b, output logic seen);
      seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (irq_out[b]) seen = 1'b1;
      end
   endtask

   task automatic set_sel(int ch, logic [7:0] p);
      if (ch < 4) begin sh_lo[(ch%4)*8 +: 8] = p; wr(2'd1, sh_lo); end
      else        begin sh_hi[(ch%4)*8 +: 8] = p; wr(2'd2, sh_hi); end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      logic seen;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1: reset state
      check("R1 irq_out", 32'(irq_out), 32'h0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         check("R1 readback", d, 32'h0);
      end

      // R2: register map and unused bits
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); check("R2 mode word", d, 32'h00FF_00FF);
      wr(2'd1, 32'h1234_5678); rd(2'd1, d); check("R2 sel lo", d, 32'h1234_5678);
      wr(2'd2, 32'h89AB_CDEF); rd(2'd2, d); check("R2 sel hi", d, 32'h89AB_CDEF);
      wr(2'd3, 32'hFEDC_BA98); rd(2'd3, d); check("R2 filter", d, 32'hFEDC_BA98);
      for (int a = 0; a < 4; a++) wr(2'(a), 32'h0);
      step(4);

      // R4 R5 R6: vector table, level mode, no filter
      foreach (VEC[i]) begin
         automatic int ch = int'(VEC[i][13:11]);
         automatic logic [7:0] p = VEC[i][10:3];
         set_sel(ch, p);
         sh_mode = 32'h0;
         sh_mode[16 + ch] = VEC[i][2];
         wr(2'd0, sh_mode);
         step(2);
         pads[p] = VEC[i][1];
         step(4);
         check("R4 R5 R6 vector", 32'(irq_out[ch]), 32'(VEC[i][0]));
         pads[p] = 1'b0;
         step(4);
      end

      sh_lo = '0; sh_hi = '0; sh_mode = '0;
      wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 0);
      step(4);

      // R3 R7 R10: edge mode on channel 1 watching pad 10
      set_sel(1, 8'd10);
      sh_mode = 32'h2; wr(2'd0, sh_mode);
      step(2);
      pads[10] = 1'b1;
      step(2); check("R3 not yet through sync", 32'(irq_out[1]), 32'h0);
      step(1); check("R7 pulse high", 32'(irq_out[1]), 32'h1);
      check("R10 other channels quiet", 32'(irq_out & 8'hFD), 32'h0);
      step(1); check("R7 pulse one clock", 32'(irq_out[1]), 32'h0);
      pads[10] = 1'b0;
      watch(5, 1, seen); check("R7 no pulse on fall", 32'(seen), 32'h0);

      // R9 R5: invert while sensed level flips, then falling edge
      sh_mode[17] = 1'b1; wr(2'd0, sh_mode);
      watch(4, 1, seen); check("R9 inversion change quiet", 32'(seen), 32'h0);
      pads[10] = 1'b1;
      watch(5, 1, seen); check("R5 rising pad ignored inverted", 32'(seen), 32'h0);
      pads[10] = 1'b0;
      step(3); check("R5 falling pad pulses", 32'(irq_out[1]), 32'h1);
      step(1); check("R7 falling pulse one clock", 32'(irq_out[1]), 32'h0);

      // R9: retarget to a pad already high
      sh_mode[17] = 1'b0; wr(2'd0, sh_mode);
      step(3);
      pads[20] = 1'b1;
      step(4);
      set_sel(1, 8'd20);
      watch(5, 1, seen); check("R9 select change quiet", 32'(seen), 32'h0);
      pads[20] = 1'b0;
      step(4);

      // R8: filter on channel 2 (level), pad 30
      set_sel(2, 8'd30);
      sh_flt = 32'h0000_0100; wr(2'd3, sh_flt);
      step(3);
      pads[30] = 1'b1; step(1); pads[30] = 1'b0;
      watch(6, 2, seen); check("R8 one-clock glitch dropped k=1", 32'(seen), 32'h0);
      pads[30] = 1'b1;
      step(3); check("R8 held 1 clock not enough", 32'(irq_out[2]), 32'h0);
      step(1); check("R8 held 2 clocks passes", 32'(irq_out[2]), 32'h1);
      sh_flt = 32'h0000_0200; wr(2'd3, sh_flt);
      pads[30] = 1'b0;
      step(5); check("R8 k=2 held 3 clocks", 32'(irq_out[2]), 32'h1);
      step(1); check("R8 k=2 held 4 clocks", 32'(irq_out[2]), 32'h0);
      pads[30] = 1'b1; step(3); pads[30] = 1'b0;
      watch(7, 2, seen); check("R8 three-clock glitch dropped k=2", 32'(seen), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule